// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI:LO Accumulation

This block performs 32-bit multiplication and division over several clock cycles and keeps its results in two architectural result registers, HI and LO. A requester presents two operands, an operation code and an accumulate mode, and pulses `start_i` while `ready_o` is high. The unit then goes busy. When the result has been written, it raises `ready_o` and `done_o` again. A multiply forms the full 64-bit product. The product can replace the HI:LO pair, be added to it, or be subtracted from it. A divide leaves the quotient in LO and the remainder in HI.

While the unit is idle, software can load HI or LO directly through two write strobes that share one data bus. The requester must not read HI/LO or issue a new operation while the unit is busy; it is expected to stall instead. A three-operand multiply is a no-accumulate multiply whose result the requester takes from LO. The operand magnitudes are handled in unsigned form, and the signs are applied when the result is written. The multiplier retires 8 product bits per cycle, and the divider performs one restoring step per cycle.

Top module: `imd_unit`

## Requirements
- R1: After reset, `ready_o` and `done_o` are 1, and `hi_o` and `lo_o` are 0.
- R2: A start is accepted only in a cycle where `ready_o` is 1. A start raised while busy has no effect on the result in progress or on its completion cycle.
- R3: `ready_o` and `done_o` always match each other. Both go low in the cycle after an accepted start, and both rise in the cycle in which HI/LO take the new result. A multiply (op 0 or 1) keeps them low for 4 cycles, and a divide (op 2 or 3) keeps them low for 32 cycles.
- R4: Op 0 (signed multiply) with accumulate mode 0 sets {HI,LO} to the 64-bit two's-complement product, so LO holds the low word of the product.
- R5: Op 1 (unsigned multiply) with accumulate mode 0 sets {HI,LO} to the 64-bit unsigned product.
- R6: For a multiply, accumulate mode 1 sets {HI,LO} to the old {HI,LO} plus the product, modulo 2^64. Modes 0 and 3 replace {HI,LO} with the product.
- R7: For a multiply, accumulate mode 2 sets {HI,LO} to the old {HI,LO} minus the product, modulo 2^64.
- R8: Op 2 (signed divide) puts in LO the quotient truncated toward zero, and in HI a remainder that carries the sign of the dividend. Dividing -2^31 by -1 gives LO=0x80000000 and HI=0.
- R9: Op 3 (unsigned divide) puts in LO the unsigned quotient and in HI the unsigned remainder.
- R10: A divide by zero sets LO to all ones and HI to the dividend. A divide ignores the accumulate mode.
- R11: `hi_wr_i` or `lo_wr_i` loads `wr_data_i` into HI or LO at the next clock edge only if `ready_o` is 1 and no start is accepted in that cycle. Otherwise the write is dropped, and HI/LO do not change while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a new operation |
| op_i | input | 2 | 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div |
| acc_i | input | 2 | 0 replace, 1 add, 2 subtract, 3 replace |
| a_i | input | 32 | Multiplicand / dividend |
| b_i | input | 32 | Multiplier / divisor |
| hi_wr_i | input | 1 | Direct write strobe for HI |
| lo_wr_i | input | 1 | Direct write strobe for LO |
| wr_data_i | input | 32 | Data for direct writes |
| ready_o | output | 1 | Unit can accept a start |
| done_o | output | 1 | HI/LO hold a valid result |
| hi_o | output | 32 | HI register |
| lo_o | output | 32 | LO register |

## Verification
The bench exercises multiplies whose operands have mixed signs and both at the minimum negative value. These cases separate correct sign restoration from plain magnitude multiplication. An all-ones unsigned multiply shows whether the high word carries the full 64-bit width. Accumulate runs build on the preceding HI:LO value, so a wrong add/subtract direction, or a reserved mode that accumulates when it should replace, shows up as a mismatch. Divides cover each sign combination, the -2^31/-1 case and division by zero, which tells truncation direction, remainder sign and the zero-divisor override apart. A run of pseudo-random operations follows. The bench also raises starts and direct writes while the unit is busy, and a write in the same cycle as a start, to show that these are dropped.

// File: rtl/imd_pkg.sv
package imd_pkg;

    localparam int unsigned XLEN = 32;

    typedef enum logic [1:0] {
        OP_SMUL = 2'd0,
        OP_UMUL = 2'd1,
        OP_SDIV = 2'd2,
        OP_UDIV = 2'd3
    } md_op_e;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_ADD  = 2'd1,
        ACC_SUB  = 2'd2,
        ACC_RSVD = 2'd3
    } md_acc_e;

    // Context captured when an operation is accepted
    typedef struct packed {
        md_op_e  op;
        md_acc_e acc;
        logic    neg_main;   // negate product or quotient
        logic    neg_rem;    // negate remainder
        logic    div_zero;   // divisor was zero
    } md_ctx_t;

    function automatic logic op_is_div(md_op_e op);
        return (op == OP_SDIV) || (op == OP_UDIV);
    endfunction

    function automatic logic op_is_signed(md_op_e op);
        return (op == OP_SMUL) || (op == OP_SDIV);
    endfunction

endpackage

// File: rtl/imd_mul_core.sv
module imd_mul_core #(
    parameter int W     = 32,
    parameter int STEPS = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   a_mag,
    input  logic [W-1:0]   b_mag,
    output logic [2*W-1:0] sum_nxt
);
    localparam int CH = W / STEPS;
    localparam int DW = 2 * W;

    logic [DW-1:0] sum_q;
    logic [DW-1:0] mcand_q;
    logic [W-1:0]  mplier_q;
    logic [DW-1:0] pp;

    // one partial product of CH multiplier bits per cycle
    assign pp      = mcand_q * {{(DW-CH){1'b0}}, mplier_q[CH-1:0]};
    assign sum_nxt = sum_q + pp;

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
        end else if (load) begin
            sum_q    <= '0;
            mcand_q  <= {{W{1'b0}}, a_mag};
            mplier_q <= b_mag;
        end else if (step) begin
            sum_q    <= sum_nxt;
            mcand_q  <= mcand_q << CH;
            mplier_q <= mplier_q >> CH;
        end
    end
endmodule

// File: rtl/imd_div_core.sv
module imd_div_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] n_mag,
    input  logic [W-1:0] d_mag,
    output logic [W-1:0] quo_nxt,
    output logic [W-1:0] rem_nxt
);
    logic [W-1:0] rem_q;
    logic [W-1:0] quo_q;
    logic [W-1:0] dsr_q;
    logic [W:0]   shifted;
    logic [W:0]   diff;
    logic         fits;

    // restoring step: bring down one dividend bit, subtract if it fits
    assign shifted = {rem_q, quo_q[W-1]};
    assign fits    = shifted >= {1'b0, dsr_q};
    assign diff    = shifted - {1'b0, dsr_q};
    assign rem_nxt = fits ? diff[W-1:0] : shifted[W-1:0];
    assign quo_nxt = {quo_q[W-2:0], fits};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            dsr_q <= '0;
        end else if (load) begin
            rem_q <= '0;
            quo_q <= n_mag;
            dsr_q <= d_mag;
        end else if (step) begin
            rem_q <= rem_nxt;
            quo_q <= quo_nxt;
        end
    end
endmodule

// File: rtl/imd_hilo_merge.sv
module imd_hilo_merge
    import imd_pkg::*;
#(
    parameter int W = 32
) (
    input  md_acc_e        acc,
    input  logic [2*W-1:0] cur,
    input  logic [2*W-1:0] prod,
    output logic [2*W-1:0] merged
);
    always_comb begin
        unique case (acc)
            ACC_ADD: merged = cur + prod;
            ACC_SUB: merged = cur - prod;
            default: merged = prod;
        endcase
    end
endmodule

// File: rtl/imd_unit.sv
module imd_unit
    import imd_pkg::*;
#(
    parameter int W         = XLEN,
    parameter int MUL_STEPS = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [1:0]   op_i,
    input  logic [1:0]   acc_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         hi_wr_i,
    input  logic         lo_wr_i,
    input  logic [W-1:0] wr_data_i,
    output logic         ready_o,
    output logic         done_o,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);
    localparam int DW        = 2 * W;
    localparam int DIV_STEPS = W;
    localparam int CW        = $clog2(DIV_STEPS + 1);

    md_op_e       op_in;
    logic         accept;
    logic         sgn_in;
    logic [W-1:0] a_mag;
    logic [W-1:0] b_mag;

    logic          busy_q;
    logic [CW-1:0] cnt_q;
    md_ctx_t       ctx_q;
    logic [W-1:0]  dividend_q;
    logic [W-1:0]  hi_q;
    logic [W-1:0]  lo_q;
    logic          finishing;

    logic [DW-1:0] prod_nxt;
    logic [DW-1:0] prod_signed;
    logic [DW-1:0] merged;
    logic [W-1:0]  quo_nxt;
    logic [W-1:0]  rem_nxt;
    logic [W-1:0]  quo_fix;
    logic [W-1:0]  rem_fix;
    logic [DW-1:0] result;

    assign op_in  = md_op_e'(op_i);
    assign accept = start_i && !busy_q;
    assign sgn_in = op_is_signed(op_in);
    assign a_mag  = (sgn_in && a_i[W-1]) ? (~a_i + W'(1)) : a_i;
    assign b_mag  = (sgn_in && b_i[W-1]) ? (~b_i + W'(1)) : b_i;

    assign finishing = busy_q && (cnt_q == CW'(1));

    imd_mul_core #(.W(W), .STEPS(MUL_STEPS)) u_mul (
        .clk     (clk),
        .rst     (rst),
        .load    (accept && !op_is_div(op_in)),
        .step    (busy_q && !op_is_div(ctx_q.op)),
        .a_mag   (a_mag),
        .b_mag   (b_mag),
        .sum_nxt (prod_nxt)
    );

    imd_div_core #(.W(W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .load    (accept && op_is_div(op_in)),
        .step    (busy_q && op_is_div(ctx_q.op)),
        .n_mag   (a_mag),
        .d_mag   (b_mag),
        .quo_nxt (quo_nxt),
        .rem_nxt (rem_nxt)
    );

    assign prod_signed = ctx_q.neg_main ? (~prod_nxt + DW'(1)) : prod_nxt;

    imd_hilo_merge #(.W(W)) u_merge (
        .acc    (ctx_q.acc),
        .cur    ({hi_q, lo_q}),
        .prod   (prod_signed),
        .merged (merged)
    );

    assign quo_fix = ctx_q.neg_main ? (~quo_nxt + W'(1)) : quo_nxt;
    assign rem_fix = ctx_q.neg_rem  ? (~rem_nxt + W'(1)) : rem_nxt;

    always_comb begin
        if (!op_is_div(ctx_q.op))
            result = merged;
        else if (ctx_q.div_zero)
            result = {dividend_q, {W{1'b1}}};
        else
            result = {rem_fix, quo_fix};
    end

    // sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q     <= 1'b0;
            cnt_q      <= '0;
            ctx_q      <= '{op: OP_SMUL, acc: ACC_NONE, neg_main: 1'b0,
                            neg_rem: 1'b0, div_zero: 1'b0};
            dividend_q <= '0;
        end else if (accept) begin
            busy_q         <= 1'b1;
            cnt_q          <= op_is_div(op_in) ? CW'(DIV_STEPS) : CW'(MUL_STEPS);
            ctx_q.op       <= op_in;
            ctx_q.acc      <= md_acc_e'(acc_i);
            ctx_q.neg_main <= sgn_in && (a_i[W-1] ^ b_i[W-1]);
            ctx_q.neg_rem  <= sgn_in && a_i[W-1];
            ctx_q.div_zero <= (b_i == '0);
            dividend_q     <= a_i;
        end else if (busy_q) begin
            cnt_q <= cnt_q - CW'(1);
            if (finishing)
                busy_q <= 1'b0;
        end
    end

    // result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (finishing) begin
            hi_q <= result[DW-1:W];
            lo_q <= result[W-1:0];
        end else if (!busy_q && !accept) begin
            if (hi_wr_i)
                hi_q <= wr_data_i;
            if (lo_wr_i)
                lo_q <= wr_data_i;
        end
    end

    assign ready_o = !busy_q;
    assign done_o  = !busy_q;
    assign hi_o    = hi_q;
    assign lo_o    = lo_q;
endmodule

// File: rtl/imd_unit_chk.sv
module imd_unit_chk #(
    parameter int W         = 32,
    parameter int MUL_STEPS = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic [1:0]   op_i,
    input logic [W-1:0] b_i,
    input logic         ready_o,
    input logic         done_o,
    input logic [W-1:0] hi_o,
    input logic [W-1:0] lo_o
);
    localparam int LCW = $clog2(W + 2) + 1;

    logic [LCW-1:0] low_cnt;
    logic [LCW-1:0] exp_lat;
    logic           dz_q;

    // counts cycles spent busy; compared with the expected latency
    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            exp_lat <= '0;
            dz_q    <= 1'b0;
        end else begin
            low_cnt <= ready_o ? '0 : low_cnt + LCW'(1);
            if (start_i && ready_o) begin
                exp_lat <= (op_i == 2'd2 || op_i == 2'd3) ? LCW'(W) : LCW'(MUL_STEPS);
                dz_q    <= (op_i == 2'd2 || op_i == 2'd3) && (b_i == '0);
            end
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ready_o && done_o && hi_o == '0 && lo_o == '0));

    assert_fall_after_start_R3: assert property (@(posedge clk) disable iff (rst)
        (start_i && ready_o) |=> (!ready_o && !done_o));

    assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> (low_cnt == exp_lat));

    assert_hold_while_busy_R11: assert property (@(posedge clk) disable iff (rst)
        !ready_o |=> (ready_o || ($stable(hi_o) && $stable(lo_o))));

    assert_divzero_lo_R10: assert property (@(posedge clk) disable iff (rst)
        ($rose(ready_o) && dz_q) |-> (lo_o == '1));
endmodule

bind imd_unit imd_unit_chk #(.W(W), .MUL_STEPS(MUL_STEPS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .op_i    (op_i),
    .b_i     (b_i),
    .ready_o (ready_o),
    .done_o  (done_o),
    .hi_o    (hi_o),
    .lo_o    (lo_o)
);

// File: tb/imd_unit_tb.sv
module imd_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'd0;
    logic [1:0]  acc_i = 2'd0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic        hi_wr_i = 1'b0;
    logic        lo_wr_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic        ready_o, done_o;
    logic [31:0] hi_o, lo_o;

    int compared = 0;
    int mismatched = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    imd_unit u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .acc_i(acc_i),
        .a_i(a_i), .b_i(b_i), .hi_wr_i(hi_wr_i), .lo_wr_i(lo_wr_i),
        .wr_data_i(wr_data_i), .ready_o(ready_o), .done_o(done_o),
        .hi_o(hi_o), .lo_o(lo_o)
    );

    // ---------------- behavioural reference model ----------------
    logic        m_busy = 1'b0;
    int          m_cnt = 0;
    logic [31:0] m_hi = '0, m_lo = '0;
    logic [63:0] m_pend = '0;

    function automatic logic [63:0] ref_result(input logic [1:0] op, input logic [1:0] acc,
                                               input logic [31:0] a, input logic [31:0] b,
                                               input logic [63:0] hilo);
        logic [63:0] p;
        longint sa, sb, q, r;
        if (op == 2'd0 || op == 2'd1) begin
            if (op == 2'd0) p = 64'(longint'($signed(a)) * longint'($signed(b)));
            else            p = {32'b0, a} * {32'b0, b};
            if (acc == 2'd1)      return hilo + p;
            else if (acc == 2'd2) return hilo - p;
            else                  return p;
        end
        if (b == 0) return {a, 32'hFFFF_FFFF};
        if (op == 2'd2) begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
            q = sa / sb;
            r = sa % sb;
            return {r[31:0], q[31:0]};
        end
        return {a % b, a / b};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 1'b0; m_cnt = 0; m_hi = '0; m_lo = '0;
        end else if (m_busy) begin
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) begin
                m_busy = 1'b0;
                {m_hi, m_lo} = m_pend;
            end
        end else if (start_i) begin
            m_pend = ref_result(op_i, acc_i, a_i, b_i, {m_hi, m_lo});
            m_cnt  = op_i[1] ? 32 : 4;
            m_busy = 1'b1;
        end else begin
            if (hi_wr_i) m_hi = wr_data_i;
            if (lo_wr_i) m_lo = wr_data_i;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            compared++;
            if (ready_o !== !m_busy || done_o !== !m_busy) begin
                mismatched++;
                $display("FAIL R3 (%s): ready=%b done=%b expected %b", cur_req,
                         ready_o, done_o, !m_busy);
            end else if (hi_o !== m_hi || lo_o !== m_lo) begin
                mismatched++;
                $display("FAIL %s: hi=%h lo=%h expected hi=%h lo=%h", cur_req,
                         hi_o, lo_o, m_hi, m_lo);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic launch(input logic [1:0] op, input logic [1:0] acc,
                          input logic [31:0] a, input logic [31:0] b, input string req);
        cur_req = req;
        op_i = op; acc_i = acc; a_i = a; b_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40; i++) begin
            if (!m_busy) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic run(input logic [1:0] op, input logic [1:0] acc,
                       input logic [31:0] a, input logic [31:0] b, input string req);
        launch(op, acc, a, b, req);
        wait_idle();
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        mismatched++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] lcg;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: explicit reset-state check
        compared++;
        if (!(ready_o && done_o && hi_o == 0 && lo_o == 0)) begin
            mismatched++;
            $display("FAIL R1: ready=%b done=%b hi=%h lo=%h expected 1 1 0 0",
                     ready_o, done_o, hi_o, lo_o);
        end

        run(2'd0, 2'd0, 32'hFFFF_FFFD, 32'd7, "R4");
        run(2'd0, 2'd0, 32'h8000_0000, 32'h8000_0000, "R4");
        run(2'd1, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5");
        run(2'd1, 2'd1, 32'h0001_0000, 32'h0001_0000, "R6");
        run(2'd0, 2'd2, 32'd5, 32'd5, "R7");
        run(2'd0, 2'd2, 32'hFFFF_FFFF, 32'h7FFF_FFFF, "R7");
        run(2'd0, 2'd3, 32'd2, 32'd3, "R6");

        // R2 / R11: start and direct writes raised while busy are dropped
        launch(2'd1, 2'd0, 32'd100, 32'd200, "R2");
        @(negedge clk);
        op_i = 2'd3; a_i = 32'd9; b_i = 32'd0; start_i = 1'b1;
        hi_wr_i = 1'b1; lo_wr_i = 1'b1; wr_data_i = 32'hDEAD_BEEF;
        @(negedge clk);
        start_i = 1'b0; hi_wr_i = 1'b0; lo_wr_i = 1'b0;
        wait_idle();

        run(2'd2, 2'd0, 32'hFFFF_FFF9, 32'd2, "R8");
        run(2'd2, 2'd0, 32'd7, 32'hFFFF_FFFE, "R8");
        run(2'd2, 2'd0, 32'h8000_0000, 32'hFFFF_FFFF, "R8");
        run(2'd3, 2'd0, 32'hFFFF_FFFF, 32'd3, "R9");
        run(2'd3, 2'd0, 32'd7, 32'd9, "R9");
        run(2'd2, 2'd0, 32'hFFFF_FFFB, 32'd0, "R10");
        run(2'd3, 2'd1, 32'd123, 32'd0, "R10");
        run(2'd3, 2'd2, 32'd100, 32'd7, "R10");

        // R11: direct writes while idle, then accumulate onto them
        cur_req = "R11";
        hi_wr_i = 1'b1; wr_data_i = 32'h0000_1234;
        @(negedge clk);
        hi_wr_i = 1'b0; lo_wr_i = 1'b1; wr_data_i = 32'h0000_5678;
        @(negedge clk);
        lo_wr_i = 1'b0;
        @(negedge clk);
        run(2'd1, 2'd1, 32'd2, 32'd3, "R11");
        // R11: write coincident with an accepted start is dropped
        hi_wr_i = 1'b1; wr_data_i = 32'hBAD0_0BAD;
        launch(2'd1, 2'd1, 32'd1, 32'd1, "R11");
        hi_wr_i = 1'b0;
        wait_idle();

        lcg = 32'h1357_9BDF;
        for (int k = 0; k < 24; k++) begin
            logic [31:0] x, y;
            lcg = lcg * 32'd1664525 + 32'd1013904223; x = lcg;
            lcg = lcg * 32'd1664525 + 32'd1013904223; y = lcg;
            if (k % 5 == 4) y = 32'd0;
            run(2'(k % 4), 2'((k / 4) % 4), x, y,
                (k % 4 == 0) ? "R4" : (k % 4 == 1) ? "R5" : (k % 4 == 2) ? "R8" : "R9");
        end

        finish_run();
    end
endmodule